// File: doc/BRIEF.md
# Dual-Mode SPI Register Slave

This block is an SPI slave that gives an external master read and write access to a small on-chip register file. The interface runs in clock-polarity-0, clock-phase-0 form. Every transfer begins with a command byte, sent most significant bit first, that carries a register address and a direction flag. After the command byte the transfer carries one or more data bytes. If chip select stays low, the address steps forward by one for each further byte.

Two wiring modes are available, and a configuration input chooses between them. In full-duplex mode, read data goes out on a dedicated serial output. In half-duplex mode there is only one data wire. The master drives it for the command byte and for any write data. On a read, the slave takes the wire over once the eighth rising serial-clock edge has passed, and the dedicated output is never driven. Pad drivers sit outside the block, so every driven line appears as a value and enable pair.

All logic runs on one system clock. The serial clock, the chip select and the data input pass through synchronizer flops, and serial-clock edges are found by comparing delayed copies. The register file connects through a simple port: an address, a one-cycle write strobe with write data, and a one-cycle read strobe with read data that is valid in the same cycle.

Top module: `spi_dual_slave`

## Requirements
- R1: The data input is sampled on each rising serial-clock edge while chip select is low. The first bit of every byte is its most significant bit.
- R2: In the command byte, bits [7:3] hold the register address and bit 1 holds the direction, where 1 means write and 0 means read. The values of bits 2 and 0 have no effect.
- R3: After the eighth data bit of a write byte, exactly one cycle of reg_wr_o is produced, carrying the current address and the received byte. reg_wr_o and reg_rd_o are never high together.
- R4: In full-duplex mode, a read returns the register contents on miso_o, most significant bit first. Each bit is valid before the rising edge on which the master samples it. miso_oe_o is high for as long as chip select is low and low whenever chip select is high.
- R5: In half-duplex mode, a read returns the register contents on mosi_o, most significant bit first. mosi_oe_o stays low until the eighth rising edge of the command byte and is high for the data phase.
- R6: mosi_oe_o is never high on a write transfer in either mode, and never high at all in full-duplex mode.
- R7: In half-duplex mode, miso_oe_o stays low at all times.
- R8: Raising chip select at any point clears the bit count and the command state, and drops both output enables. A write byte that is cut short produces no write strobe, and the next transfer decodes a fresh command byte.
- R9: If chip select stays low after a data byte, another byte follows in the same direction at the next address. The 5-bit address wraps from 31 to 0.
- R10: The mode input is captured only while chip select is high. A change to it during a transfer has no effect until that transfer ends.
- R11: After reset, both output enables and both register strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_half_i | input | 1 | 1 selects half-duplex wiring, 0 selects full-duplex |
| sclk_i | input | 1 | Serial clock from the master, idle low |
| ss_n_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Value seen on the master-to-slave data pad |
| mosi_o | output | 1 | Value the slave drives on the shared data pad in half-duplex reads |
| mosi_oe_o | output | 1 | Output enable for mosi_o |
| miso_o | output | 1 | Serial read data in full-duplex mode |
| miso_oe_o | output | 1 | Output enable for miso_o |
| reg_addr_o | output | 5 | Register file address |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, valid in the cycle of reg_rd_o |

## Verification
Single-byte reads and writes run in both modes. Command bytes with the ignored bits set and with them cleared show that only the address and direction fields are decoded. The bench watches which enable comes up and in which bit slot, so a half-duplex turnaround that comes early, late or on the wrong pin is told apart from a correct one. Three-byte bursts, including one that wraps past address 31, separate true address stepping from a repeated first byte. A write cut short and a mode input flipped mid-transfer show that chip select alone restarts the state and fixes the mode.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

  // Position of the direction flag inside the command byte
  localparam int CMD_DIR_BIT = 1;

  typedef enum logic {
    XFER_READ  = 1'b0,
    XFER_WRITE = 1'b1
  } xfer_dir_e;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic ss_n_i,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic ss_n_o,
  output logic mosi_o
);

  localparam int NSIG = 3;
  // Idle levels per line: {mosi, ss_n, sclk}
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b010;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sclk_q;

  assign raw = {mosi_i, ss_n_i, sclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_chain
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= synced[0];
  end

  assign sclk_rise_o = synced[0] & ~sclk_q;
  assign sclk_fall_o = ~synced[0] & sclk_q;
  assign ss_n_o      = synced[1];
  assign mosi_o      = synced[2];

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_dual_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  input  logic              mode_half_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              tx_bit_o,
  output logic              rd_phase_o,
  output logic              mode_half_o
);

  localparam int               CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt_q,  bit_cnt_n;
  logic [DATA_W-1:0] rx_q,       rx_n;
  logic [DATA_W-1:0] tx_q,       tx_n;
  logic [DATA_W-1:0] wdata_q,    wdata_n;
  logic [ADDR_W-1:0] addr_q,     addr_n;
  logic              cmd_done_q, cmd_done_n;
  xfer_dir_e         dir_q,      dir_n;
  logic              rd_pend_q,  rd_pend_n;
  logic              wr_pend_q,  wr_pend_n;
  logic              out_q,      out_n;
  logic              mode_q,     mode_n;

  logic [DATA_W-1:0] byte_in;
  logic [CNT_W-1:0]  tx_idx;

  assign byte_in = {rx_q[DATA_W-2:0], mosi_i};
  assign tx_idx  = LAST_BIT - bit_cnt_q;

  always_comb begin
    bit_cnt_n  = bit_cnt_q;
    rx_n       = rx_q;
    tx_n       = tx_q;
    wdata_n    = wdata_q;
    addr_n     = addr_q;
    cmd_done_n = cmd_done_q;
    dir_n      = dir_q;
    out_n      = out_q;
    mode_n     = mode_q;
    rd_pend_n  = 1'b0;
    wr_pend_n  = 1'b0;
    if (ss_n_i) begin
      bit_cnt_n  = '0;
      rx_n       = '0;
      cmd_done_n = 1'b0;
      dir_n      = XFER_READ;
      out_n      = 1'b0;
      mode_n     = mode_half_i;
    end else begin
      if (rd_pend_q) begin
        tx_n  = reg_rdata_i;
        out_n = reg_rdata_i[DATA_W-1];
      end
      if (wr_pend_q) addr_n = addr_q + 1'b1;
      if (sclk_rise_i) begin
        rx_n      = byte_in;
        bit_cnt_n = bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST_BIT) begin
          if (!cmd_done_q) begin
            cmd_done_n = 1'b1;
            addr_n     = byte_in[DATA_W-1 -: ADDR_W];
            dir_n      = xfer_dir_e'(byte_in[CMD_DIR_BIT]);
            rd_pend_n  = ~byte_in[CMD_DIR_BIT];
          end else if (dir_q == XFER_WRITE) begin
            wr_pend_n = 1'b1;
            wdata_n   = byte_in;
          end else begin
            addr_n    = addr_q + 1'b1;
            rd_pend_n = 1'b1;
          end
        end
      end else if (sclk_fall_i && cmd_done_q && dir_q == XFER_READ) begin
        out_n = tx_q[tx_idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      wdata_q    <= '0;
      addr_q     <= '0;
      cmd_done_q <= 1'b0;
      dir_q      <= XFER_READ;
      rd_pend_q  <= 1'b0;
      wr_pend_q  <= 1'b0;
      out_q      <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      bit_cnt_q  <= bit_cnt_n;
      rx_q       <= rx_n;
      tx_q       <= tx_n;
      wdata_q    <= wdata_n;
      addr_q     <= addr_n;
      cmd_done_q <= cmd_done_n;
      dir_q      <= dir_n;
      rd_pend_q  <= rd_pend_n;
      wr_pend_q  <= wr_pend_n;
      out_q      <= out_n;
      mode_q     <= mode_n;
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_wr_o    = wr_pend_q;
  assign reg_wdata_o = wdata_q;
  assign reg_rd_o    = rd_pend_q;
  assign tx_bit_o    = out_q;
  assign rd_phase_o  = cmd_done_q && (dir_q == XFER_READ);
  assign mode_half_o = mode_q;

  // R3: strobes come one at a time, each right after a serial rising edge
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));
  a_r3_wr_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> $past(sclk_rise_i));
  // R10: the captured mode holds for as long as chip select stays low
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n_i && $past(!ss_n_i)) |-> $stable(mode_q));
  // R8: chip select high returns the engine to its idle command state
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_i |=> (!rd_phase_o && bit_cnt_q == '0));

endmodule

// File: rtl/spi_pad_ctrl.sv
module spi_pad_ctrl (
  input  logic ss_n_i,
  input  logic mode_half_i,
  input  logic rd_phase_i,
  input  logic tx_bit_i,
  output logic mosi_o,
  output logic mosi_oe_o,
  output logic miso_o,
  output logic miso_oe_o
);

  always_comb begin
    mosi_oe_o = ~ss_n_i & mode_half_i & rd_phase_i;
    miso_oe_o = ~ss_n_i & ~mode_half_i;
    mosi_o    = mosi_oe_o & tx_bit_i;
    miso_o    = miso_oe_o & tx_bit_i;
  end

endmodule

// File: rtl/spi_dual_slave.sv
module spi_dual_slave #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_half_i,
  input  logic              sclk_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);

  logic rst_meta_q, rst_sync_n;
  logic sclk_rise, sclk_fall, ss_n_s, mosi_s;
  logic tx_bit, rd_phase, mode_half_q;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sclk_i      (sclk_i),
    .ss_n_i      (ss_n_i),
    .mosi_i      (mosi_i),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .ss_n_o      (ss_n_s),
    .mosi_o      (mosi_s)
  );

  spi_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .ss_n_i      (ss_n_s),
    .mosi_i      (mosi_s),
    .mode_half_i (mode_half_i),
    .reg_addr_o  (reg_addr_o),
    .reg_wr_o    (reg_wr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rd_o    (reg_rd_o),
    .reg_rdata_i (reg_rdata_i),
    .tx_bit_o    (tx_bit),
    .rd_phase_o  (rd_phase),
    .mode_half_o (mode_half_q)
  );

  spi_pad_ctrl u_pads (
    .ss_n_i      (ss_n_s),
    .mode_half_i (mode_half_q),
    .rd_phase_i  (rd_phase),
    .tx_bit_i    (tx_bit),
    .mosi_o      (mosi_o),
    .mosi_oe_o   (mosi_oe_o),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe_o)
  );

  // R5: the shared line is taken over only right after a serial rising edge
  a_r5_turn_on_edge: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mosi_oe_o) |-> $past(sclk_rise));
  // R6/R7: never two slave drivers at once
  a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mosi_oe_o && miso_oe_o));
  // R8: a deselected slave drives nothing
  a_r8_released: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ss_n_s |-> !(mosi_oe_o || miso_oe_o));

endmodule

// File: tb/tb_spi_dual_slave.sv
module tb_spi_dual_slave;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_half;
  logic       sclk;
  logic       ss_n;
  logic       mosi_in;
  logic       mosi_o, mosi_oe, miso_o, miso_oe;
  logic [4:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] mem [32];
  logic [7:0] wdb [3];
  logic [7:0] rdb [3];
  bit   early_oe, mosi_seen, miso_seen, miso_gap, released;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  always #2 clk = ~clk;

  spi_dual_slave dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_half_i (mode_half),
    .sclk_i      (sclk),
    .ss_n_i      (ss_n),
    .mosi_i      (mosi_in),
    .mosi_o      (mosi_o),
    .mosi_oe_o   (mosi_oe),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe),
    .reg_addr_o  (reg_addr),
    .reg_wr_o    (reg_wr),
    .reg_wdata_o (reg_wdata),
    .reg_rd_o    (reg_rd),
    .reg_rdata_i (reg_rdata)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'(a * 37 + 11);
  endfunction

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= init_val(i);
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One transfer; abort_bits > 0 raises chip select after that many bits
  task automatic xfer(input bit half, input logic [7:0] cmd, input int nbytes,
                      input int abort_bits, input bit flip_mode);
    int total;
    mode_half = half;
    early_oe = 0; mosi_seen = 0; miso_seen = 0; miso_gap = 0;
    for (int k = 0; k < 3; k++) rdb[k] = 8'h00;
    total = (abort_bits > 0) ? abort_bits : 8 + 8 * nbytes;
    repeat (8) @(negedge clk);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < total; b++) begin
      int byi = (b - 8) / 8;
      int bi  = 7 - ((b - 8) % 8);
      if (b < 8)       mosi_in = cmd[7 - b];
      else if (cmd[1]) mosi_in = wdb[byi][bi];
      else             mosi_in = 1'b1;
      if (flip_mode && b == 4) mode_half = ~half;
      repeat (8) @(negedge clk);
      if (b < 8 && mosi_oe) early_oe = 1;
      if (mosi_oe) mosi_seen = 1;
      if (miso_oe) miso_seen = 1;
      if (!half && !miso_oe) miso_gap = 1;
      if (b >= 8 && !cmd[1]) rdb[byi][bi] = half ? mosi_o : miso_o;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      if (b < 7 && mosi_oe) early_oe = 1;
      if (mosi_oe) mosi_seen = 1;
      if (miso_oe) miso_seen = 1;
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    released = !mosi_oe && !miso_oe;
    mode_half = half;
  endtask

  task automatic t_reset;
    chk(!mosi_oe && !miso_oe, "R11", "enables after reset", {mosi_oe, miso_oe}, 0);
    chk(!reg_wr && !reg_rd, "R11", "strobes after reset", {reg_wr, reg_rd}, 0);
  endtask

  task automatic t_full_write;
    wdb[0] = 8'hA5;
    xfer(0, {5'd5, 1'b1, 1'b1, 1'b1}, 1, 0, 0);  // R2: bits 2 and 0 set
    chk(mem[5] == 8'hA5, "R1", "full write reg5", mem[5], 8'hA5);
    chk(mem[5] == 8'hA5 && mem[4] == init_val(4), "R2", "junk bits ignored", mem[4], init_val(4));
    chk(!mosi_seen, "R6", "full write mosi_oe", mosi_seen, 0);
    chk(released, "R8", "release after write", released, 1);
  endtask

  task automatic t_full_read;
    xfer(0, {5'd9, 3'b000}, 1, 0, 0);
    chk(rdb[0] == init_val(9), "R4", "full read reg9", rdb[0], init_val(9));
    chk(!miso_gap, "R4", "miso_oe held while selected", miso_gap, 0);
    chk(!mosi_seen, "R6", "full read mosi_oe", mosi_seen, 0);
    chk(released, "R4", "miso_oe off when deselected", released, 1);
  endtask

  task automatic t_half_read;
    xfer(1, {5'd17, 1'b1, 1'b0, 1'b1}, 1, 0, 0);
    chk(rdb[0] == init_val(17), "R5", "half read reg17", rdb[0], init_val(17));
    chk(!early_oe, "R5", "no drive in command byte", early_oe, 0);
    chk(mosi_seen, "R5", "mosi_oe in data phase", mosi_seen, 1);
    chk(!miso_seen, "R7", "miso_oe in half read", miso_seen, 0);
    chk(released, "R8", "release after half read", released, 1);
  endtask

  task automatic t_half_write;
    wdb[0] = 8'h3C;
    xfer(1, {5'd3, 3'b010}, 1, 0, 0);
    chk(mem[3] == 8'h3C, "R6", "half write reg3", mem[3], 8'h3C);
    chk(!mosi_seen, "R6", "half write mosi_oe", mosi_seen, 0);
    chk(!miso_seen, "R7", "miso_oe in half write", miso_seen, 0);
  endtask

  task automatic t_burst;
    wdb[0] = 8'h11; wdb[1] = 8'h22; wdb[2] = 8'h33;
    xfer(0, {5'd12, 3'b010}, 3, 0, 0);
    chk(mem[12] == 8'h11, "R9", "burst write 12", mem[12], 8'h11);
    chk(mem[13] == 8'h22, "R9", "burst write 13", mem[13], 8'h22);
    chk(mem[14] == 8'h33, "R9", "burst write 14", mem[14], 8'h33);
    xfer(1, {5'd12, 3'b000}, 3, 0, 0);
    chk(rdb[0] == 8'h11 && rdb[1] == 8'h22 && rdb[2] == 8'h33, "R9",
        "half burst read", {rdb[0], rdb[1], rdb[2]}, 24'h112233);
    xfer(0, {5'd30, 3'b000}, 3, 0, 0);
    chk(rdb[0] == init_val(30) && rdb[1] == init_val(31) && rdb[2] == init_val(0),
        "R9", "address wrap read", {rdb[0], rdb[1], rdb[2]},
        {init_val(30), init_val(31), init_val(0)});
  endtask

  task automatic t_abort;
    wdb[0] = 8'hF0;
    xfer(0, {5'd20, 3'b010}, 1, 12, 0);
    chk(released, "R8", "release after abort", released, 1);
    chk(mem[20] == init_val(20), "R8", "no write from cut byte", mem[20], init_val(20));
    xfer(0, {5'd20, 3'b000}, 1, 0, 0);
    chk(rdb[0] == init_val(20), "R8", "fresh command after abort", rdb[0], init_val(20));
  endtask

  task automatic t_mode_freeze;
    xfer(0, {5'd9, 3'b000}, 1, 0, 1);
    chk(rdb[0] == init_val(9), "R10", "full read kept after flip", rdb[0], init_val(9));
    chk(!mosi_seen, "R10", "no mosi drive after flip", mosi_seen, 0);
    xfer(1, {5'd17, 3'b000}, 1, 0, 1);
    chk(rdb[0] == init_val(17), "R10", "half read kept after flip", rdb[0], init_val(17));
    chk(!miso_seen, "R10", "no miso drive after flip", miso_seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_half = 1'b0; sclk = 1'b0; ss_n = 1'b1; mosi_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_write();
    t_full_read();
    t_half_read();
    t_half_write();
    t_burst();
    t_abort();
    t_mode_freeze();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule